// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block produces the internal reset for a small microcontroller core and keeps two sticky flags, a time-out flag and a power-down flag, that tell software why the most recent reset happened. Four kinds of event start a reset: a power-up detect pulse, the active-low master-clear pin, a watchdog time-out pulse, and either of the last two arriving while the core is asleep. A wake from sleep is treated as a full reset, and the core does not resume where it stopped.

A set/reset latch holds the core in reset. A start-up delay counter, advanced by a slow oscillator tick, clears the latch once it reaches its terminal count. The counter advances only while the synchronized master-clear pin reads high, so a pin held low keeps the core in reset for as long as it stays low. While reset is held, the block drives load strobes and reset values for the program-counter low byte, the port direction registers and the option register, and a clear strobe for the page-select status bits. The flags are written only at the moment a reset event is captured. The release of that reset does not change them.

Top module: `rst_seq`

## Requirements
- R1: `porDetect` high forces `coreReset`, `timeOut` and `powerDown` to 1 without waiting for a clock edge and clears the delay counter. It has no effect once it falls. With `mclrN` high and `oscTick` held at 1, `coreReset` first reads 0 after the (TERM_COUNT+2)th rising edge following the fall of `porDetect`.
- R2: The delay counter advances only on cycles where `oscTick` is 1 and the synchronized pin is high. If `oscTick` stays 0, or if `mclrN` stays 0 (including while leaving a power-up), `coreReset` stays 1 indefinitely.
- R3: A one-cycle `wdtTimeout` pulse sets `coreReset` after the next rising edge. At that same edge `timeOut` becomes 0 and `powerDown` becomes the inverse of `sleepMode` (1 when running, 0 when asleep). With `oscTick` at 1, `coreReset` first reads 0 after the (TERM_COUNT+2)th edge counted from the pulse edge.
- R4: `mclrN` low passes through a two-flop synchronizer, and `coreReset` is 1 after the third rising edge. With `oscTick` at 1, `coreReset` first reads 0 after the (TERM_COUNT+4)th edge following the rise of `mclrN`.
- R5: A master-clear event with `sleepMode` 0 leaves both flags unchanged. With `sleepMode` 1 it sets `timeOut`=1 and `powerDown`=0.
- R6: If a watchdog pulse and a synchronized master-clear falling edge land in the same cycle, the watchdog rule decides the flags.
- R7: If `mclrN` goes low while the delay is counting, the count is discarded and the full delay of R4 restarts from the next rise. `coreReset` does not drop in between.
- R8: The end of a reset never changes `timeOut` or `powerDown`.
- R9: `loadPcl`, `loadTris`, `loadOption` and `clearPage` equal `coreReset`. The reset values are `pclInit`=8'hFF and `trisInit`=8'hFF. `optionInit` is 8'h3F: its low six bits are ones and bits 7:6 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| porDetect | input | 1 | Power-up detect pulse, active high, asynchronous |
| mclrN | input | 1 | External master-clear pin, active low, asynchronous |
| wdtTimeout | input | 1 | Watchdog time-out pulse, one cycle |
| sleepMode | input | 1 | Core is in sleep |
| oscTick | input | 1 | Enable from the slow start-up oscillator |
| coreReset | output | 1 | Internal chip reset, active high |
| timeOut | output | 1 | Sticky time-out cause flag |
| powerDown | output | 1 | Sticky power-down cause flag |
| loadPcl | output | 1 | Load strobe, program-counter low byte |
| loadTris | output | 1 | Load strobe, direction registers |
| loadOption | output | 1 | Load strobe, option register |
| clearPage | output | 1 | Clear strobe, status page-select bits |
| pclInit | output | 8 | Reset value of the program-counter low byte |
| trisInit | output | 8 | Reset value of the direction registers |
| optionInit | output | 8 | Reset value of the option register |

## Verification
A watchdog pulse shows its effect one edge later. A master-clear edge reaches the latch and the flags three edges later, because it passes through the two synchronizer flops first. The release shows at TERM_COUNT+2 edges from a power-up or watchdog event and at TERM_COUNT+4 edges from the rise of the pin, and the extra two edges are the release stage. The bench drives every input on a falling clock edge and samples on falling edges. It counts rising edges until `coreReset` falls and compares that count with the exact figure above, so a release that comes one edge early or one edge late is reported.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  // Command from the control half to the datapath half.
  typedef struct packed {
    logic setLatch;   // hold or enter reset, clear the delay count
    logic capture;    // write the cause flags this cycle
    logic newTo;      // value for the time-out flag
    logic newPd;      // value for the power-down flag
  } seqCmd_t;
endpackage

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic    clk,
  input  logic    porDetect,
  input  logic    mclrN,
  input  logic    wdtTimeout,
  input  logic    sleepMode,
  output logic    mclrHigh,
  output seqCmd_t cmd
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] syncChain;
  logic mclrPrev;
  logic pinFall;

  // Two-flop synchronizer for the asynchronous pin.
  always_ff @(posedge clk) begin
    syncChain <= {syncChain[SYNC_STAGES-2:0], mclrN};
  end

  assign mclrHigh = syncChain[SYNC_STAGES-1];

  // Cleared at power-up so that a low pin then is not mistaken for an edge.
  always_ff @(posedge clk or posedge porDetect) begin
    if (porDetect) mclrPrev <= 1'b0;
    else           mclrPrev <= mclrHigh;
  end

  assign pinFall = mclrPrev & ~mclrHigh;

  always_comb begin
    cmd.setLatch = wdtTimeout | ~mclrHigh;
    cmd.capture  = wdtTimeout | (pinFall & sleepMode);
    if (wdtTimeout) begin
      cmd.newTo = 1'b0;
      cmd.newPd = ~sleepMode;
    end else begin
      cmd.newTo = 1'b1;
      cmd.newPd = 1'b0;
    end
  end
endmodule

// File: rtl/rst_seq_core.sv
module rst_seq_core
  import rst_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int TERM_COUNT = 255,
  parameter int REL_STAGES = 2
) (
  input  logic    clk,
  input  logic    porDetect,
  input  logic    oscTick,
  input  logic    mclrHigh,
  input  seqCmd_t cmd,
  output logic    coreReset,
  output logic    timeOut,
  output logic    powerDown
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM_COUNT - 1);

  logic             holdLatch;
  logic [CNT_W-1:0] delayCnt;
  logic [REL_STAGES-1:0] relPipe;
  logic             advance;

  assign advance = holdLatch & mclrHigh & oscTick;

  // Reset latch and start-up delay counter.
  always_ff @(posedge clk or posedge porDetect) begin
    if (porDetect) begin
      holdLatch <= 1'b1;
      delayCnt  <= '0;
    end else if (cmd.setLatch) begin
      holdLatch <= 1'b1;
      delayCnt  <= '0;
    end else if (advance) begin
      if (delayCnt == LAST) begin
        holdLatch <= 1'b0;
        delayCnt  <= '0;
      end else begin
        delayCnt <= delayCnt + 1'b1;
      end
    end
  end

  // Cause flags, written only when an event is captured.
  always_ff @(posedge clk or posedge porDetect) begin
    if (porDetect) begin
      timeOut   <= 1'b1;
      powerDown <= 1'b1;
    end else if (cmd.capture) begin
      timeOut   <= cmd.newTo;
      powerDown <= cmd.newPd;
    end
  end

  // Release stage: entry is immediate, exit is delayed and retimed.
  always_ff @(posedge clk or posedge porDetect) begin
    if (porDetect) relPipe <= '1;
    else           relPipe <= {relPipe[REL_STAGES-2:0], holdLatch};
  end

  assign coreReset = holdLatch | relPipe[REL_STAGES-1];
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int TERM_COUNT = 255,
  parameter int DATA_W     = 8,
  parameter int OPT_BITS   = 6
) (
  input  logic              clk,
  input  logic              porDetect,
  input  logic              mclrN,
  input  logic              wdtTimeout,
  input  logic              sleepMode,
  input  logic              oscTick,
  output logic              coreReset,
  output logic              timeOut,
  output logic              powerDown,
  output logic              loadPcl,
  output logic              loadTris,
  output logic              loadOption,
  output logic              clearPage,
  output logic [DATA_W-1:0] pclInit,
  output logic [DATA_W-1:0] trisInit,
  output logic [DATA_W-1:0] optionInit
);
  seqCmd_t cmd;
  logic    mclrHigh;

  rst_seq_ctrl u_ctrl (
    .clk        (clk),
    .porDetect  (porDetect),
    .mclrN      (mclrN),
    .wdtTimeout (wdtTimeout),
    .sleepMode  (sleepMode),
    .mclrHigh   (mclrHigh),
    .cmd        (cmd)
  );

  rst_seq_core #(
    .CNT_W      (CNT_W),
    .TERM_COUNT (TERM_COUNT),
    .REL_STAGES (2)
  ) u_core (
    .clk       (clk),
    .porDetect (porDetect),
    .oscTick   (oscTick),
    .mclrHigh  (mclrHigh),
    .cmd       (cmd),
    .coreReset (coreReset),
    .timeOut   (timeOut),
    .powerDown (powerDown)
  );

  assign loadPcl    = coreReset;
  assign loadTris   = coreReset;
  assign loadOption = coreReset;
  assign clearPage  = coreReset;

  assign pclInit    = '1;
  assign trisInit   = '1;
  assign optionInit = DATA_W'((1 << OPT_BITS) - 1);
endmodule

// File: rtl/rst_seq_checker.sv
module rst_seq_checker (
  input logic clk,
  input logic porDetect,
  input logic wdtTimeout,
  input logic sleepMode,
  input logic coreReset,
  input logic timeOut,
  input logic powerDown
);
  assert_wdt_forces_reset_R3: assert property (@(posedge clk) disable iff (porDetect)
    wdtTimeout |=> coreReset);

  assert_wdt_run_flags_R3: assert property (@(posedge clk) disable iff (porDetect)
    (wdtTimeout && !sleepMode) |=> (!timeOut && powerDown));

  assert_wdt_sleep_flags_R3: assert property (@(posedge clk) disable iff (porDetect)
    (wdtTimeout && sleepMode) |=> (!timeOut && !powerDown));

  assert_flags_hold_at_release_R8: assert property (@(posedge clk) disable iff (porDetect)
    $fell(coreReset) |-> $stable({timeOut, powerDown}));

  assert_no_release_after_wdt_R3: assert property (@(posedge clk) disable iff (porDetect)
    $fell(coreReset) |-> !$past(wdtTimeout));
endmodule

bind rst_seq rst_seq_checker u_checker (
  .clk        (clk),
  .porDetect  (porDetect),
  .wdtTimeout (wdtTimeout),
  .sleepMode  (sleepMode),
  .coreReset  (coreReset),
  .timeOut    (timeOut),
  .powerDown  (powerDown)
);

// File: tb/rst_seq_test.sv
module rst_seq_test;
  localparam int TERM = 6;

  logic clk = 1'b0;
  logic porDetect, mclrN, wdtTimeout, sleepMode, oscTick;
  logic coreReset, timeOut, powerDown;
  logic loadPcl, loadTris, loadOption, clearPage;
  logic [7:0] pclInit, trisInit, optionInit;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rst_seq #(.CNT_W(8), .TERM_COUNT(TERM)) uut (
    .clk(clk), .porDetect(porDetect), .mclrN(mclrN), .wdtTimeout(wdtTimeout),
    .sleepMode(sleepMode), .oscTick(oscTick), .coreReset(coreReset),
    .timeOut(timeOut), .powerDown(powerDown), .loadPcl(loadPcl),
    .loadTris(loadTris), .loadOption(loadOption), .clearPage(clearPage),
    .pclInit(pclInit), .trisInit(trisInit), .optionInit(optionInit)
  );

  // Row: {isWatchdog, sleep, expected timeOut, expected powerDown}
  localparam logic [3:0] VEC [8] = '{
    4'b1001, 4'b0001, 4'b1100, 4'b0110,
    4'b0010, 4'b1001, 4'b0110, 4'b1100
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic waitRelease(output int n);
    n = 0;
    while (coreReset && n < 400) begin
      step();
      n++;
    end
  endtask

  task automatic checkStrobes(input string req);
    check({loadPcl, loadTris, loadOption, clearPage} == {4{coreReset}}, req,
          {loadPcl, loadTris, loadOption, clearPage}, {4{coreReset}});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    porDetect = 1'b1; mclrN = 1'b1; wdtTimeout = 1'b0; sleepMode = 1'b0; oscTick = 1'b1;
    #1;
    // R1: asynchronous entry
    check(coreReset && timeOut && powerDown, "R1 reset state", {coreReset, timeOut, powerDown}, 7);
    repeat (4) step();
    // R9: strobes and values while held
    checkStrobes("R9 strobes in reset");
    check(pclInit == 8'hFF, "R9 pclInit", pclInit, 8'hFF);
    check(trisInit == 8'hFF, "R9 trisInit", trisInit, 8'hFF);
    check(optionInit == 8'h3F, "R9 optionInit", optionInit, 8'h3F);
    porDetect = 1'b0;
    waitRelease(n);
    check(n == TERM + 2, "R1 power-up delay", n, TERM + 2);
    check(timeOut && powerDown, "R8 flags after power-up release", {timeOut, powerDown}, 3);
    checkStrobes("R9 strobes after release");

    // Table of cause events
    for (int i = 0; i < 8; i++) begin
      logic isWdt, slp, eTo, ePd;
      {isWdt, slp, eTo, ePd} = VEC[i];
      sleepMode = slp;
      if (isWdt) begin
        wdtTimeout = 1'b1;
        step();
        wdtTimeout = 1'b0;
        check(coreReset, "R3 watchdog enters reset", coreReset, 1);
        check({timeOut, powerDown} == {eTo, ePd}, "R3 watchdog flags",
              {timeOut, powerDown}, {eTo, ePd});
        sleepMode = 1'b0;
        waitRelease(n);
        check(n == TERM + 2, "R3 watchdog delay", n, TERM + 2);
      end else begin
        mclrN = 1'b0;
        step(); step();
        check(!coreReset, "R4 two sync edges before entry", coreReset, 0);
        step();
        check(coreReset, "R4 pin entry at third edge", coreReset, 1);
        check({timeOut, powerDown} == {eTo, ePd}, "R5 pin flags",
              {timeOut, powerDown}, {eTo, ePd});
        step();
        sleepMode = 1'b0;
        mclrN = 1'b1;
        waitRelease(n);
        check(n == TERM + 4, "R4 pin delay", n, TERM + 4);
      end
      check({timeOut, powerDown} == {eTo, ePd}, "R8 flags kept at release",
            {timeOut, powerDown}, {eTo, ePd});
    end

    // R6: watchdog and pin edge in the same cycle, asleep
    sleepMode = 1'b1;
    mclrN = 1'b0;
    step(); step();
    wdtTimeout = 1'b1;
    step();
    wdtTimeout = 1'b0;
    check({timeOut, powerDown} == 2'b00, "R6 watchdog wins", {timeOut, powerDown}, 0);
    sleepMode = 1'b0;
    step();
    mclrN = 1'b1;
    waitRelease(n);
    check(n == TERM + 4, "R6 release after combined event", n, TERM + 4);

    // R7: pin dips mid-count
    mclrN = 1'b0;
    repeat (4) step();
    mclrN = 1'b1;
    repeat (5) step();
    check(coreReset, "R7 still counting", coreReset, 1);
    mclrN = 1'b0;
    repeat (3) step();
    check(coreReset, "R7 held through dip", coreReset, 1);
    mclrN = 1'b1;
    waitRelease(n);
    check(n == TERM + 4, "R7 full delay restarts", n, TERM + 4);

    // R2: no ticks, no release
    oscTick = 1'b0;
    wdtTimeout = 1'b1;
    step();
    wdtTimeout = 1'b0;
    repeat (40) step();
    check(coreReset, "R2 held without ticks", coreReset, 1);
    oscTick = 1'b1;
    waitRelease(n);
    check(n == TERM + 2, "R2 counts once ticks resume", n, TERM + 2);

    // R1/R2: power-up with the pin low, asleep
    sleepMode = 1'b1;
    mclrN = 1'b0;
    porDetect = 1'b1;
    #1;
    check(coreReset && timeOut && powerDown, "R1 second power-up", {coreReset, timeOut, powerDown}, 7);
    step(); step();
    porDetect = 1'b0;
    repeat (30) step();
    check(coreReset, "R2 pin low holds after power-up", coreReset, 1);
    check(timeOut && powerDown, "R5 no false pin event after power-up",
          {timeOut, powerDown}, 3);
    sleepMode = 1'b0;
    mclrN = 1'b1;
    waitRelease(n);
    check(n == TERM + 4, "R4 release after low pin at power-up", n, TERM + 4);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule